// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer for a small microcontroller. Software programs it through one five-bit control register. The register holds a run (enable) bit, an unlock (change-enable) bit and a three-bit scale select. While the watchdog runs, a timeout counter advances once for each pulse on the watchdog tick input. Software must strobe the kick input before the selected number of ticks has passed. If it does not, the block raises a one-cycle reset request on `bite` and the count starts again from zero.

Turning the watchdog on is a single write. Turning it off is guarded against stray writes. Software first writes the unlock and run bits both as one in the same write. It then has four clock cycles in which a write with the run bit at zero stops the watchdog. A write that clears the run bit at any other time is ignored. The unlock bit clears itself when the window expires, and it also clears when the window is used.

Register layout, used by both `cfg_wdata` and `ctrl_q`: bits [2:0] hold the scale select, bit 3 is the run bit and bit 4 is the unlock bit. The timeout is 2^(BASE_LOG2 + scale) ticks. With the default BASE_LOG2 of 14, scale codes 0 to 7 give 16,384 up to 2,097,152 ticks.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `ctrl_q` reads 0 (stopped, window closed, scale 0) and `bite` is 0.
- R2: A write with bit 3 set to 1 sets the run bit on that write, whether or not the block was stopped, and loads bits [2:0] as the new scale select.
- R3: A write with bits 4 and 3 both at 1 opens the unlock window, and `ctrl_q[4]` reads 1 from the cycle after that write.
- R4: A write with bit 3 at 0 that arrives on the 1st, 2nd, 3rd or 4th clock cycle after the opening write stops the watchdog, so `ctrl_q[3]` reads 0.
- R5: A write with bit 3 at 0 at any other time is ignored, and `ctrl_q[3]` stays 1.
- R6: `ctrl_q[4]` returns to 0 four cycles after the opening write. It also returns to 0 as soon as a write uses the window to stop the watchdog.
- R7: While running, `bite` goes high in the cycle after the 2^(BASE_LOG2+scale)-th tick counted since the counter was last zero, and counting restarts from zero.
- R8: `bite` is high for exactly one cycle for each timeout.
- R9: `kick` clears the timeout counter to zero and takes priority over a tick in the same cycle.
- R10: Starting the watchdog does not clear the counter. Ticks that arrive while it is stopped do not advance the counter.
- R11: `bite` never rises while the watchdog is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Write data: [4] unlock, [3] run, [2:0] scale |
| kick | input | 1 | Watchdog reset strobe; clears the counter |
| tick | input | 1 | One-cycle pulse from the watchdog time base |
| ctrl_q | output | 5 | Control register: [4] window open, [3] running, [2:0] scale |
| bite | output | 1 | One-cycle reset request on timeout |

## Verification
The hardest situation to reach is a stop write landing exactly on a window boundary: the fourth cycle after the opening write, where the stop must succeed, and the fifth, where it must be ignored. The bench reaches it by issuing the opening write and then waiting a swept number of idle cycles, from one to five, before the stop write. A second hard case is a count that carries over a stop and a later restart. The bench builds it by stopping the watchdog partway through a timeout, ticking while stopped, and restarting without a kick, so that a single further tick must produce the reset request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SCALE_W = 3;

  typedef struct packed {
    logic                 unlock;
    logic                 run;
    logic [SCALE_W-1:0]   scale;
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);

  // Last count value before wrap: 2^(base+scale) - 1
  function automatic logic [31:0] wdt_term(input int unsigned base,
                                           input logic [SCALE_W-1:0] scale);
    return (32'd1 << (base + 32'(scale))) - 32'd1;
  endfunction

  // A write that arms the stop window carries unlock and run together
  function automatic logic wdt_is_arm(input wdt_ctrl_t w);
    return w.unlock & w.run;
  endfunction

endpackage

// File: rtl/wdt_unlock_win.sv
module wdt_unlock_win #(
  parameter int WIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic consume,
  output logic open
);
  localparam int WW = $clog2(WIN_CYCLES + 1);

  logic [WW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            left_q <= '0;
    else if (arm)          left_q <= WW'(WIN_CYCLES);
    else if (consume)      left_q <= '0;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign open = (left_q != '0);

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  wdt_ctrl_t          wdata,
  input  logic               win_open,
  output logic               run_q,
  output logic [SCALE_W-1:0] scale_q,
  output logic               arm_evt,
  output logic               stop_evt
);

  assign arm_evt  = we & wdt_is_arm(wdata);
  assign stop_evt = we & ~wdata.run & win_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      scale_q <= '0;
    end else if (we) begin
      scale_q <= wdata.scale;
      if (wdata.run)     run_q <= 1'b1;
      else if (win_open) run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + (1 << SCALE_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SCALE_W-1:0] scale,
  input  logic               kick,
  input  logic               tick,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               wrap_evt,
  output logic               bite_q
);

  logic [CNT_W-1:0] term;

  assign term     = CNT_W'(wdt_term(BASE_LOG2, scale));
  assign wrap_evt = run & tick & ~kick & (cnt_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      bite_q <= wrap_evt;
      if (kick)             cnt_q <= '0;
      else if (wrap_evt)    cnt_q <= '0;
      else if (run && tick) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2  = 14,
  parameter int WIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              kick,
  input  logic              tick,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              bite
);
  localparam int CNT_W = BASE_LOG2 + (1 << SCALE_W) - 1;

  wdt_ctrl_t          wdata;
  logic               win_open;
  logic               run_q;
  logic [SCALE_W-1:0] scale_q;
  logic               arm_evt;
  logic               stop_evt;
  logic [CNT_W-1:0]   cnt_q;
  logic               wrap_evt;

  assign wdata = cfg_wdata;

  wdt_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (wdata),
    .win_open (win_open),
    .run_q    (run_q),
    .scale_q  (scale_q),
    .arm_evt  (arm_evt),
    .stop_evt (stop_evt)
  );

  wdt_unlock_win #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm_evt),
    .consume (stop_evt),
    .open    (win_open)
  );

  wdt_timeout_cnt #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .scale    (scale_q),
    .kick     (kick),
    .tick     (tick),
    .cnt_q    (cnt_q),
    .wrap_evt (wrap_evt),
    .bite_q   (bite)
  );

  assign ctrl_q = {win_open, run_q, scale_q};

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int WIN_CYCLES = 4,
  parameter int CNT_W      = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [4:0]       cfg_wdata,
  input logic             kick,
  input logic [4:0]       ctrl_q,
  input logic             bite,
  input logic             arm_evt,
  input logic [CNT_W-1:0] cnt_q
);
  localparam int AW = $clog2(WIN_CYCLES + 2) + 1;

  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                       age_q <= '0;
    else if (arm_evt)                                 age_q <= AW'(1);
    else if (age_q != '0 && age_q <= AW'(WIN_CYCLES)) age_q <= age_q + 1'b1;
  end

  assert_run_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[3] |=> ctrl_q[3]);

  assert_arm_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[4] && cfg_wdata[3] |=> ctrl_q[4]);

  assert_stop_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[3] && ctrl_q[4] |=> !ctrl_q[3] && !ctrl_q[4]);

  assert_stop_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[3] && !ctrl_q[4] && ctrl_q[3] |=> ctrl_q[3]);

  assert_window_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> (age_q != '0) && (age_q <= AW'(WIN_CYCLES)));

  assert_restart_after_bite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bite |-> cnt_q == '0);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> !bite);

  assert_kick_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt_q == '0);

  assert_no_bite_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bite) |-> $past(ctrl_q[3]));

endmodule

bind wdt_guard wdt_guard_chk #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .kick      (kick),
  .ctrl_q    (ctrl_q),
  .bite      (bite),
  .arm_evt   (arm_evt),
  .cnt_q     (cnt_q)
);

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       kick = 1'b0;
  logic       tick = 1'b0;
  logic [4:0] ctrl_q;
  logic       bite;

  int checks = 0;
  int fails  = 0;
  int bites_seen = 0;
  bit done = 1'b0;

  // Timeout in ticks per scale code, for BASE_LOG2 = 2
  localparam int TICKS [8] = '{4, 8, 16, 32, 64, 128, 256, 512};

  always #2 clk = ~clk;

  wdt_guard #(.BASE_LOG2(2), .WIN_CYCLES(4)) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .kick(kick), .tick(tick), .ctrl_q(ctrl_q), .bite(bite)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Apply n ticks, count bites seen after each
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (bite) bites_seen++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(ctrl_q == 5'b0, "R1 ctrl after reset", ctrl_q, 0);
    chk(bite == 1'b0, "R1 bite after reset", bite, 0);
    rst_n = 1'b1;
    idle(1);

    // Table walk over every scale code
    for (int s = 0; s < 8; s++) begin
      do_kick();
      wr({2'b01, 3'(s)});
      chk(ctrl_q == {2'b01, 3'(s)}, "R2 run and scale loaded", ctrl_q, {2'b01, 3'(s)});
      bites_seen = 0;
      ticks(TICKS[s] - 1);
      chk(bites_seen == 0, "R7 no bite before timeout", bites_seen, 0);
      ticks(1);
      chk(bite == 1'b1, "R7 bite at timeout", bite, 1);
      idle(1);
      chk(bite == 1'b0, "R8 bite lasts one cycle", bite, 0);
    end

    // Stop write at 1..4 cycles after the opening write succeeds
    for (int k = 1; k <= 4; k++) begin
      wr(5'b11_000);
      chk(ctrl_q[4] == 1'b1, "R3 window open", ctrl_q[4], 1);
      idle(k - 1);
      wr(5'b00_000);
      chk(ctrl_q[3] == 1'b0, "R4 stop inside window", ctrl_q[3], 0);
      chk(ctrl_q[4] == 1'b0, "R6 window closes when used", ctrl_q[4], 0);
      wr(5'b01_000);
      chk(ctrl_q[3] == 1'b1, "R2 restart from stopped", ctrl_q[3], 1);
    end

    // Stop write on the fifth cycle is too late
    wr(5'b11_000);
    idle(4);
    wr(5'b00_000);
    chk(ctrl_q[3] == 1'b1, "R5 stop after window ignored", ctrl_q[3], 1);

    // Window self-clears
    wr(5'b11_000);
    idle(3);
    chk(ctrl_q[4] == 1'b1, "R6 window still open on 4th cycle", ctrl_q[4], 1);
    idle(1);
    chk(ctrl_q[4] == 1'b0, "R6 window self-clears", ctrl_q[4], 0);

    // Stop with no window at all
    wr(5'b00_000);
    chk(ctrl_q[3] == 1'b1, "R5 unguarded stop ignored", ctrl_q[3], 1);

    // Count survives stop and restart; stopped ticks do not count
    do_kick();
    bites_seen = 0;
    ticks(3);
    wr(5'b11_000);
    wr(5'b00_000);
    chk(ctrl_q[3] == 1'b0, "R4 stopped for carry test", ctrl_q[3], 0);
    ticks(6);
    chk(bites_seen == 0, "R11 no bite while stopped", bites_seen, 0);
    wr(5'b01_000);
    ticks(1);
    chk(bite == 1'b1, "R10 count kept across restart", bite, 1);
    idle(1);

    // Kick clears a partial count
    do_kick();
    bites_seen = 0;
    ticks(3);
    do_kick();
    ticks(3);
    chk(bites_seen == 0, "R9 kick restarts count", bites_seen, 0);
    ticks(1);
    chk(bite == 1'b1, "R9 full timeout after kick", bite, 1);
    idle(1);

    // Kick and tick together: kick wins
    ticks(3);
    kick = 1'b1; tick = 1'b1;
    @(negedge clk);
    kick = 1'b0; tick = 1'b0;
    bites_seen = 0;
    ticks(3);
    chk(bites_seen == 0, "R9 kick beats tick", bites_seen, 0);

    // Reset mid-run
    wr(5'b11_101);
    rst_n = 1'b0;
    idle(1);
    chk(ctrl_q == 5'b0, "R1 ctrl after mid-run reset", ctrl_q, 0);
    rst_n = 1'b1;
    idle(1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule